// File: doc/BRIEF.md
# Bus Address Parity Error Responder

This block watches the address phase on each interface of a two-port bus bridge. On every transaction it folds the multiplexed address/data lines and the command/byte-enable lines into an even-parity check. It then compares the result with the parity line, which the bus presents one clock after the address. From that result and two command-register bits it decides three things: whether the bridge may claim the transaction, whether the sticky status flags are set, and whether a one-clock active-low system-error pulse is driven.

The claim decision waits for the late parity line. The decode hit, which is sampled with the address, is turned into a one-clock claim-enable that the bridge's target logic uses to gate its device-select response. When the parity-error-response bit is set, a parity failure withholds the claim, so the initiator ends the cycle in a master abort. Every interface has its own checker and its own status flags. Software clears the flags with write-one-to-clear strobes.

Top module: `addr_parity_guard`

## Requirements
- R1: An address phase is the first clock in which `bus_frame_n` of an interface is low after a clock in which it was high. Only that clock is captured. Holding `bus_frame_n` low longer starts no further check, and a claim is issued at most once per transaction.
- R2: Parity is even. An error exists when the XOR of all 32 address lines and all 4 command/byte-enable lines (as seen on the bus) in the address clock, together with `bus_par` in the following clock, equals 1. This holds for every one of the 16 command codes.
- R3: `claim_en` goes high for exactly one clock, in the clock after the parity clock, when `dec_hit` was high in the address clock and the claim is not withheld by R4. Otherwise it stays low.
- R4: When a parity error is found and `cmd_par_resp` (sampled in the parity clock) is 1, `claim_en` stays low even if the decode hit.
- R5: When a parity error is found and `cmd_par_resp` is 0, `claim_en` follows the decode hit as in R3.
- R6: `sts_dpe` becomes 1 in the clock after the parity clock of any errored address, whatever the command bits are.
- R7: `serr_n` is low for exactly one clock and `sts_sse` is set, both in the clock after the parity clock, only when there is a parity error and both `cmd_par_resp` and `cmd_serr_en` are 1. Otherwise `serr_n` stays high and `sts_sse` is not set.
- R8: `sts_dpe` and `sts_sse` are sticky. Each clears only by reset or by a 1 on its clear strobe at a clock edge. If a set and a clear of the same flag fall on the same edge, the flag ends up 1.
- R9: The interfaces are independent. Traffic, errors and clears on one interface never change the outputs of another.
- R10: While `rst` is high and after it is released, `claim_en` and both status flags are 0 and `serr_n` is 1 until an address phase drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_frame_n | input | NP | Frame line per interface, active low |
| bus_ad | input | NP*AW | Address/data lines, interface i at bits [i*AW +: AW] |
| bus_cbe_n | input | NP*CW | Command/byte-enable lines, interface i at bits [i*CW +: CW] |
| bus_par | input | NP | Parity line per interface, valid the clock after the address |
| cmd_par_resp | input | NP | Parity-error-response command bit |
| cmd_serr_en | input | NP | System-error enable command bit |
| dec_hit | input | NP | Address decode hit, sampled in the address clock |
| sts_dpe_clr | input | NP | Write-one-to-clear strobe for the detected-parity flag |
| sts_sse_clr | input | NP | Write-one-to-clear strobe for the signaled-system-error flag |
| claim_en | output | NP | One-clock permission to assert device select |
| sts_dpe | output | NP | Sticky detected-parity-error flag |
| sts_sse | output | NP | Sticky signaled-system-error flag |
| serr_n | output | NP | System-error pulse, active low |

## Verification
A flag's set from a parity error and its write-one-to-clear can land on the same clock edge. The bench provokes this by raising `sts_dpe_clr` in exactly the clock where the bad `bus_par` is presented, and it then expects the flag to read 1. The second coincidence is errors on both interfaces in the same clock, and on one interface while the other runs clean traffic. There the bench checks that each interface's flags, claim and pulse follow only its own stimulus. Both cases are also compared on every clock against a behavioural model of the flags.

// File: rtl/apg_pkg.sv
package apg_pkg;

  // Captured address-phase information carried to the parity clock
  typedef struct packed {
    logic pend;   // an address phase was seen on the previous edge
    logic fold;   // XOR of address and command lines
    logic hit;    // decode hit at the address phase
  } apg_capture_t;

  function automatic logic apg_fold(input logic [63:0] lines, input int unsigned width);
    logic r;
    r = 1'b0;
    for (int unsigned k = 0; k < 64; k++) begin
      if (k < width) r = r ^ lines[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/apg_phase_capture.sv
module apg_phase_capture
  import apg_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_n,
  input  logic [AW-1:0] ad,
  input  logic [CW-1:0] cbe_n,
  input  logic          hit,
  output apg_capture_t  cap
);
  localparam int LW = AW + CW;

  logic          frame_n_q;
  logic [63:0]   lines;
  logic          start;

  always_comb begin
    lines         = '0;
    lines[LW-1:0] = {ad, cbe_n};
  end

  assign start = frame_n_q & ~frame_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_n_q <= 1'b1;
      cap       <= '0;
    end else begin
      frame_n_q <= frame_n;
      cap.pend  <= start;
      cap.fold  <= apg_fold(lines, LW);
      cap.hit   <= hit;
    end
  end
endmodule

// File: rtl/apg_parity_eval.sv
module apg_parity_eval
  import apg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  apg_capture_t cap,
  input  logic         par,
  input  logic         par_resp,
  input  logic         serr_en,
  output logic         dpe_set,
  output logic         sse_set,
  output logic         claim,
  output logic         serr_n
);
  logic err;

  assign err     = cap.pend & (cap.fold ^ par);
  assign dpe_set = err;
  assign sse_set = err & par_resp & serr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      claim  <= 1'b0;
      serr_n <= 1'b1;
    end else begin
      claim  <= cap.pend & cap.hit & ~(err & par_resp);
      serr_n <= ~sse_set;
    end
  end
endmodule

// File: rtl/apg_sticky_bit.sv
module apg_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/addr_parity_guard.sv
module addr_parity_guard
  import apg_pkg::*;
#(
  parameter int NP = 2,
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    bus_frame_n,
  input  logic [NP*AW-1:0] bus_ad,
  input  logic [NP*CW-1:0] bus_cbe_n,
  input  logic [NP-1:0]    bus_par,
  input  logic [NP-1:0]    cmd_par_resp,
  input  logic [NP-1:0]    cmd_serr_en,
  input  logic [NP-1:0]    dec_hit,
  input  logic [NP-1:0]    sts_dpe_clr,
  input  logic [NP-1:0]    sts_sse_clr,
  output logic [NP-1:0]    claim_en,
  output logic [NP-1:0]    sts_dpe,
  output logic [NP-1:0]    sts_sse,
  output logic [NP-1:0]    serr_n
);
  for (genvar i = 0; i < NP; i++) begin : g_port
    apg_capture_t cap;
    logic         dpe_set;
    logic         sse_set;

    apg_phase_capture #(.AW(AW), .CW(CW)) u_cap (
      .clk     (clk),
      .rst     (rst),
      .frame_n (bus_frame_n[i]),
      .ad      (bus_ad[i*AW +: AW]),
      .cbe_n   (bus_cbe_n[i*CW +: CW]),
      .hit     (dec_hit[i]),
      .cap     (cap)
    );

    apg_parity_eval u_eval (
      .clk      (clk),
      .rst      (rst),
      .cap      (cap),
      .par      (bus_par[i]),
      .par_resp (cmd_par_resp[i]),
      .serr_en  (cmd_serr_en[i]),
      .dpe_set  (dpe_set),
      .sse_set  (sse_set),
      .claim    (claim_en[i]),
      .serr_n   (serr_n[i])
    );

    apg_sticky_bit u_dpe (
      .clk (clk), .rst (rst), .set (dpe_set), .clr (sts_dpe_clr[i]), .q (sts_dpe[i])
    );

    apg_sticky_bit u_sse (
      .clk (clk), .rst (rst), .set (sse_set), .clr (sts_sse_clr[i]), .q (sts_sse[i])
    );
  end
endmodule

// File: rtl/apg_checker.sv
module apg_checker #(
  parameter int NP = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [NP-1:0] dec_hit,
  input logic [NP-1:0] cmd_par_resp,
  input logic [NP-1:0] cmd_serr_en,
  input logic [NP-1:0] sts_dpe_clr,
  input logic [NP-1:0] sts_sse_clr,
  input logic [NP-1:0] claim_en,
  input logic [NP-1:0] sts_dpe,
  input logic [NP-1:0] sts_sse,
  input logic [NP-1:0] serr_n
);
  for (genvar i = 0; i < NP; i++) begin : g_chk
    AST_SERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      !serr_n[i] |=> serr_n[i]); // R7
    AST_SERR_WITH_SSE: assert property (@(posedge clk) disable iff (rst)
      !serr_n[i] |-> sts_sse[i]); // R7
    AST_SERR_NEEDS_BOTH_BITS: assert property (@(posedge clk) disable iff (rst)
      !serr_n[i] |-> $past(cmd_par_resp[i] & cmd_serr_en[i])); // R7
    AST_CLAIM_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
      claim_en[i] |=> !claim_en[i]); // R3
    AST_CLAIM_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
      claim_en[i] |-> $past(dec_hit[i], 2)); // R5
    AST_WITHHOLD_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
      ($rose(sts_dpe[i]) && $past(cmd_par_resp[i])) |-> !claim_en[i]); // R4
    AST_DPE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (sts_dpe[i] && !sts_dpe_clr[i]) |=> sts_dpe[i]); // R8
    AST_SSE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (sts_sse[i] && !sts_sse_clr[i]) |=> sts_sse[i]); // R8
  end
endmodule

bind addr_parity_guard apg_checker #(.NP(NP)) u_apg_checker (
  .clk          (clk),
  .rst          (rst),
  .dec_hit      (dec_hit),
  .cmd_par_resp (cmd_par_resp),
  .cmd_serr_en  (cmd_serr_en),
  .sts_dpe_clr  (sts_dpe_clr),
  .sts_sse_clr  (sts_sse_clr),
  .claim_en     (claim_en),
  .sts_dpe      (sts_dpe),
  .sts_sse      (sts_sse),
  .serr_n       (serr_n)
);

// File: tb/addr_parity_guard_test.sv
module addr_parity_guard_test;
  localparam int NP = 2;
  localparam int AW = 32;
  localparam int CW = 4;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    bus_frame_n = '1;
  logic [NP*AW-1:0] bus_ad = '0;
  logic [NP*CW-1:0] bus_cbe_n = '0;
  logic [NP-1:0]    bus_par = '0;
  logic [NP-1:0]    cmd_par_resp = '0;
  logic [NP-1:0]    cmd_serr_en = '0;
  logic [NP-1:0]    dec_hit = '0;
  logic [NP-1:0]    sts_dpe_clr = '0;
  logic [NP-1:0]    sts_sse_clr = '0;
  logic [NP-1:0]    claim_en, sts_dpe, sts_sse, serr_n;

  int checks = 0;
  int bad = 0;
  int cycles = 0;

  addr_parity_guard #(.NP(NP), .AW(AW), .CW(CW)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_valid = 0;
  bit m_prev_fr[NP];
  bit m_pend[NP];
  bit m_fold[NP];
  bit m_hit[NP];
  bit m_claim[NP], m_dpe[NP], m_sse[NP], m_serr[NP];

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        m_prev_fr[p] = 1; m_pend[p] = 0; m_claim[p] = 0;
        m_dpe[p] = 0; m_sse[p] = 0; m_serr[p] = 1;
      end else begin
        bit err;
        err = m_pend[p] && (m_fold[p] ^ bus_par[p]);
        m_claim[p] = m_pend[p] && m_hit[p] && !(err && cmd_par_resp[p]);
        m_serr[p]  = !(err && cmd_par_resp[p] && cmd_serr_en[p]);
        m_dpe[p]   = (m_dpe[p] && !sts_dpe_clr[p]) || err;
        m_sse[p]   = (m_sse[p] && !sts_sse_clr[p]) || !m_serr[p];
        m_pend[p]  = m_prev_fr[p] && !bus_frame_n[p];
        m_fold[p]  = ^{bus_ad[p*AW +: AW], bus_cbe_n[p*CW +: CW]};
        m_hit[p]   = dec_hit[p];
        m_prev_fr[p] = bus_frame_n[p];
      end
    end
    m_valid = 1;
  end

  always @(negedge clk) begin
    if (m_valid) begin
      for (int p = 0; p < NP; p++) begin
        check("R3 model claim_en", claim_en[p], m_claim[p]);
        check("R6 model sts_dpe", sts_dpe[p], m_dpe[p]);
        check("R7 model sts_sse", sts_sse[p], m_sse[p]);
        check("R7 model serr_n", serr_n[p], m_serr[p]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic txn(int p, logic [31:0] a, logic [3:0] c, bit perr, bit hit,
                     bit per, bit se, bit hold);
    @(negedge clk);
    bus_frame_n[p] = 0;
    bus_ad[p*AW +: AW] = a;
    bus_cbe_n[p*CW +: CW] = c;
    dec_hit[p] = hit;
    @(negedge clk);
    bus_frame_n[p] = hold ? 1'b0 : 1'b1;
    bus_par[p] = (^{a, c}) ^ perr;
    cmd_par_resp[p] = per;
    cmd_serr_en[p] = se;
    dec_hit[p] = 0;
    bus_ad[p*AW +: AW] = ~a;
    @(negedge clk);
    bus_frame_n[p] = 1;
    bus_par[p] = ~bus_par[p];
  endtask

  task automatic clear(int p);
    @(negedge clk);
    sts_dpe_clr[p] = 1; sts_sse_clr[p] = 1;
    @(negedge clk);
    sts_dpe_clr[p] = 0; sts_sse_clr[p] = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state while reset held
    for (int p = 0; p < NP; p++) begin
      check("R10 claim_en in reset", claim_en[p], 0);
      check("R10 sts_dpe in reset", sts_dpe[p], 0);
      check("R10 sts_sse in reset", sts_sse[p], 0);
      check("R10 serr_n in reset", serr_n[p], 1);
    end
    rst = 0;
    repeat (2) @(negedge clk);
    check("R10 claim_en after reset", claim_en[0], 0);

    // R3: good parity with hit -> one-clock claim
    txn(0, 32'h1234_5678, 4'h6, 0, 1, 1, 1, 0);
    check("R3 claim on clean hit", claim_en[0], 1);
    check("R2 no error on clean parity", sts_dpe[0], 0);
    @(negedge clk);
    check("R3 claim lasts one clock", claim_en[0], 0);

    // R3: good parity, no hit -> no claim
    txn(0, 32'hDEAD_BEEF, 4'h7, 0, 0, 1, 1, 0);
    check("R3 no claim without hit", claim_en[0], 0);

    // R4 / R6 / R7: error, response on, serr enabled
    txn(0, 32'h0000_00F0, 4'hA, 1, 1, 1, 1, 0);
    check("R4 claim withheld on error", claim_en[0], 0);
    check("R6 dpe set", sts_dpe[0], 1);
    check("R7 sse set", sts_sse[0], 1);
    check("R7 serr_n low", serr_n[0], 0);
    @(negedge clk);
    check("R7 serr_n released", serr_n[0], 1);
    repeat (3) @(negedge clk);
    check("R8 dpe sticky", sts_dpe[0], 1);
    check("R8 sse sticky", sts_sse[0], 1);
    clear(0);
    check("R8 dpe cleared", sts_dpe[0], 0);
    check("R8 sse cleared", sts_sse[0], 0);

    // R5 / R6 / R7: error, response off
    txn(0, 32'h8000_0001, 4'h2, 1, 1, 0, 1, 0);
    check("R5 claim proceeds when response off", claim_en[0], 1);
    check("R6 dpe set with response off", sts_dpe[0], 1);
    check("R7 no sse when response off", sts_sse[0], 0);
    check("R7 serr_n high when response off", serr_n[0], 1);
    clear(0);

    // R7: error, response on, serr disabled
    txn(0, 32'h5555_AAAA, 4'hB, 1, 1, 1, 0, 0);
    check("R7 no sse with serr disabled", sts_sse[0], 0);
    check("R7 serr_n high with serr disabled", serr_n[0], 1);
    check("R6 dpe set with serr disabled", sts_dpe[0], 1);
    clear(0);

    // R8: set and clear on the same edge -> set wins
    fork
      txn(0, 32'h0F0F_0F0F, 4'h3, 1, 0, 1, 1, 0);
      begin
        @(negedge clk); @(negedge clk);
        sts_dpe_clr[0] = 1; sts_sse_clr[0] = 1;
        @(negedge clk);
        sts_dpe_clr[0] = 0; sts_sse_clr[0] = 0;
      end
    join
    check("R8 set wins over clear dpe", sts_dpe[0], 1);
    check("R8 set wins over clear sse", sts_sse[0], 1);
    clear(0);

    // R1: frame held low -> single check, single claim
    txn(0, 32'hCAFE_F00D, 4'hC, 0, 1, 1, 1, 1);
    check("R1 claim once for held frame", claim_en[0], 1);
    @(negedge clk);
    check("R1 no repeat claim", claim_en[0], 0);
    @(negedge clk);
    check("R1 no repeat claim later", claim_en[0], 0);

    // R2: every command code, alternating good and bad parity
    for (int c = 0; c < 16; c++) begin
      bit e;
      e = c[0];
      txn(0, 32'h1357_9BDF ^ (c * 32'h0101_0101), c[3:0], e, 1, 0, 0, 0);
      check("R2 parity result for command", sts_dpe[0], e);
      clear(0);
    end

    // R9: errors on port 1 while port 0 runs clean traffic
    fork
      txn(0, 32'h2468_ACE0, 4'h6, 0, 1, 1, 1, 0);
      txn(1, 32'h1111_2222, 4'h7, 1, 1, 1, 1, 0);
    join
    check("R9 port0 unaffected dpe", sts_dpe[0], 0);
    check("R9 port0 claims", claim_en[0], 1);
    check("R9 port0 serr_n high", serr_n[0], 1);
    check("R9 port1 dpe set", sts_dpe[1], 1);
    check("R9 port1 serr_n low", serr_n[1], 0);
    clear(0);
    check("R9 clear on port0 leaves port1", sts_dpe[1], 1);
    clear(1);
    check("R9 port1 cleared", sts_dpe[1], 0);

    // R9: both ports erroring on the same clock
    fork
      txn(0, 32'h0000_0003, 4'h1, 1, 1, 1, 1, 0);
      txn(1, 32'h0000_0007, 4'h1, 1, 1, 0, 0, 0);
    join
    check("R9 port0 serr_n low", serr_n[0], 0);
    check("R9 port1 serr_n high", serr_n[1], 1);
    check("R9 port1 claims", claim_en[1], 1);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule